// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block is the part of a small 16-bit segmented processor core that moves the machine into an interrupt handler and back out again. It holds the code segment, instruction pointer, stack segment, stack pointer and flag word. At each instruction boundary it decides whether an interrupt or a return is due. For an interrupt it works out an 8-bit type number from the highest-priority source. It then saves the flag word and the return address on the word-wide stack, masks tracing and maskable interrupts, and reads the handler address from the vector table in low memory.

All memory traffic goes over one byte-wide port whose read data arrives in the same cycle as the address. The rest of the core marks instruction ends with a one-cycle boundary strobe. At that strobe it presents the cause flags of the finishing instruction (divide fault, breakpoint, overflow trap, software interrupt with its operand, interrupt return). It loads the architectural registers through a parallel load port while the sequencer is idle. A maskable request is acknowledged for one cycle, and during that cycle the type byte is taken from the data bus.

Top module: `vis_int_seq`

## Requirements
- R1: After reset, busy and done are low, all five registers read zero, and no memory read, memory write or acknowledge is driven while the block is idle.
- R2: The table entry for type t starts at byte address 4·t, below 0x400. Bytes 0 and 1 give the new IP and bytes 2 and 3 give the new CS, low byte first. With AE 00 34 12 stored at 0xA4–0xA7, type 41 ends at CS:IP = 1234:00AE.
- R3: Entry pushes the flag word, then CS, then IP. Each push first lowers SP by 2 and then writes the low byte at SS·16+SP and the high byte at SS·16+SP+1, so SP ends 6 lower.
- R4: Entry clears the trace flag (bit 8) and the enable flag (bit 9) after the flag word is saved. Every other flag bit is kept.
- R5: An interrupt return pops IP, then CS, then the flag word. Each pop reads the word at SS·16+SP and then raises SP by 2, which restores all three values and SP.
- R6: A rising edge on the non-maskable input is latched and served as type 2 at the next boundary, whatever the enable flag says. Holding the input high does not raise a second request.
- R7: A maskable request is taken only at a boundary with bit 9 set. Its type is the data-bus byte sampled in the one cycle the acknowledge output is high. With bit 9 clear, the boundary leaves the block idle.
- R8: Internal causes use fixed types: divide fault 0, breakpoint 3, overflow trap 4. The overflow trap is raised only when bit 11 is set. A software interrupt uses its 8-bit operand.
- R9: A boundary seen with bit 8 set raises type 1 when nothing of higher rank is pending.
- R10: Priority from the top is: divide fault, breakpoint, overflow trap, software interrupt, interrupt return, non-maskable, maskable, single-step. A request that loses stays pending only if it is latched (the non-maskable edge) or still driven.
- R11: Busy is high from the cycle after the boundary through the done cycle. Done lasts exactly one cycle, when the new or restored CS:IP is valid. Busy lasts 11 cycles for an entry, 12 for an acknowledged entry and 7 for a return.
- R12: The register load port acts only while idle, and it takes precedence over a boundary in the same cycle. A load presented while busy changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | One-cycle strobe at the end of an instruction |
| div_err_i | input | 1 | Finishing instruction hit a divide fault |
| brk_i | input | 1 | Finishing instruction is a breakpoint |
| into_i | input | 1 | Finishing instruction is an overflow trap test |
| sw_int_i | input | 1 | Finishing instruction is a software interrupt |
| sw_type_i | input | 8 | Operand of the software interrupt |
| iret_i | input | 1 | Finishing instruction is an interrupt return |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| intr_i | input | 1 | Maskable request, level sensitive |
| inta_o | output | 1 | Acknowledge cycle; type byte is read from mem_rdata_i |
| mem_addr_o | output | 20 | Physical byte address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Write data byte |
| mem_rdata_i | input | 8 | Read data byte, valid in the same cycle |
| reg_ld_i | input | 1 | Load all five registers from the load inputs |
| cs_ld_i | input | 16 | Load value for CS |
| ip_ld_i | input | 16 | Load value for IP |
| ss_ld_i | input | 16 | Load value for SS |
| sp_ld_i | input | 16 | Load value for SP |
| flags_ld_i | input | 16 | Load value for the flag word |
| cs_o | output | 16 | Current CS |
| ip_o | output | 16 | Current IP |
| ss_o | output | 16 | Current SS |
| sp_o | output | 16 | Current SP |
| flags_o | output | 16 | Current flag word |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse: CS:IP valid |

## Verification
The bench checks the stack image byte by byte after an entry. A design that pushed in the wrong order, or that cleared the trace and enable bits before saving the flags, would leave wrong bytes in the image and would also return to wrong flags. It sends a non-maskable edge into the same boundary as a divide fault, and presents maskable and single-step requests together. A wrong priority shows up as the wrong handler address. It holds the non-maskable input high across two boundaries and raises an overflow trap with bit 11 clear. A level-triggered latch, or an overflow trap that ignores the flag, would start a spurious entry. It also drives the load port during an entry, which would corrupt SP and CS:IP if that port were not gated.

// File: rtl/vis_pkg.sv
`timescale 1ns/1ps
package vis_pkg;
  localparam int ADDR_W = 20;
  localparam int WORD_W = 16;
  localparam int TYPE_W = 8;
  localparam int BYTE_W = 8;
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;
  localparam int OF_BIT = 11;

  localparam logic [TYPE_W-1:0] T_DIV  = 8'd0;
  localparam logic [TYPE_W-1:0] T_STEP = 8'd1;
  localparam logic [TYPE_W-1:0] T_NMI  = 8'd2;
  localparam logic [TYPE_W-1:0] T_BRK  = 8'd3;
  localparam logic [TYPE_W-1:0] T_OVF  = 8'd4;

  typedef enum logic [4:0] {
    S_IDLE, S_INTA,
    S_PF0, S_PF1, S_PC0, S_PC1, S_PI0, S_PI1,
    S_V0, S_V1, S_V2, S_V3,
    S_OI0, S_OI1, S_OC0, S_OC1, S_OF0, S_OF1,
    S_DONE
  } seq_state_e;

  // segment * 16 + offset
  function automatic logic [ADDR_W-1:0] phys(input logic [WORD_W-1:0] seg,
                                             input logic [WORD_W-1:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  // byte idx of the table entry for type t
  function automatic logic [ADDR_W-1:0] vec_addr(input logic [TYPE_W-1:0] t,
                                                 input logic [1:0] idx);
    return {{(ADDR_W-TYPE_W-2){1'b0}}, t, idx};
  endfunction
endpackage

// File: rtl/vis_arbiter.sv
`timescale 1ns/1ps
module vis_arbiter
  import vis_pkg::*;
(
  input  logic              div_err,
  input  logic              brk,
  input  logic              into,
  input  logic              of_flag,
  input  logic              sw_int,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              iret,
  input  logic              nmi_pend,
  input  logic              intr,
  input  logic              if_flag,
  input  logic              tf_flag,
  output logic              take,
  output logic              ret,
  output logic [TYPE_W-1:0] type_o,
  output logic              from_intr,
  output logic              nmi_take
);
  always_comb begin
    take      = 1'b0;
    ret       = 1'b0;
    type_o    = '0;
    from_intr = 1'b0;
    nmi_take  = 1'b0;
    if (div_err) begin
      take = 1'b1; type_o = T_DIV;
    end else if (brk) begin
      take = 1'b1; type_o = T_BRK;
    end else if (into && of_flag) begin
      take = 1'b1; type_o = T_OVF;
    end else if (sw_int) begin
      take = 1'b1; type_o = sw_type;
    end else if (iret) begin
      ret = 1'b1;
    end else if (nmi_pend) begin
      take = 1'b1; type_o = T_NMI; nmi_take = 1'b1;
    end else if (intr && if_flag) begin
      take = 1'b1; from_intr = 1'b1;
    end else if (tf_flag) begin
      take = 1'b1; type_o = T_STEP;
    end
  end
endmodule

// File: rtl/vis_nmi_edge.sv
`timescale 1ns/1ps
module vis_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= nmi_i;
      if (nmi_i && !prev_q) pend_o <= 1'b1;
      else if (clr_i)       pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vis_int_seq.sv
`timescale 1ns/1ps
module vis_int_seq
  import vis_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              div_err_i,
  input  logic              brk_i,
  input  logic              into_i,
  input  logic              sw_int_i,
  input  logic [TYPE_W-1:0] sw_type_i,
  input  logic              iret_i,
  input  logic              nmi_i,
  input  logic              intr_i,
  output logic              inta_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              reg_ld_i,
  input  logic [WORD_W-1:0] cs_ld_i,
  input  logic [WORD_W-1:0] ip_ld_i,
  input  logic [WORD_W-1:0] ss_ld_i,
  input  logic [WORD_W-1:0] sp_ld_i,
  input  logic [WORD_W-1:0] flags_ld_i,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] ss_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] flags_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e        state_q;
  logic [TYPE_W-1:0] vtype_q;
  logic [BYTE_W-1:0] lo_q;
  logic              ret_q;
  logic [WORD_W-1:0] cs_q, ip_q, ss_q, sp_q, fl_q;

  logic              nmi_pend, nmi_clr;
  logic              arb_take, arb_ret, arb_intr, arb_nmi;
  logic [TYPE_W-1:0] arb_type;
  logic              idle_w, act_w;

  // named events for the checker
  logic push_lo_w, push_hi_w, pop_lo_w, pop_hi_w, vec_rd_w, entry_done_w;

  assign idle_w  = (state_q == S_IDLE);
  assign act_w   = idle_w && boundary_i && !reg_ld_i;
  assign nmi_clr = act_w && arb_take && arb_nmi;

  vis_nmi_edge u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .clr_i(nmi_clr), .pend_o(nmi_pend)
  );

  vis_arbiter u_arb (
    .div_err(div_err_i), .brk(brk_i), .into(into_i), .of_flag(fl_q[OF_BIT]),
    .sw_int(sw_int_i), .sw_type(sw_type_i), .iret(iret_i),
    .nmi_pend(nmi_pend), .intr(intr_i), .if_flag(fl_q[IF_BIT]),
    .tf_flag(fl_q[TF_BIT]),
    .take(arb_take), .ret(arb_ret), .type_o(arb_type),
    .from_intr(arb_intr), .nmi_take(arb_nmi)
  );

  assign push_lo_w = (state_q == S_PF0) || (state_q == S_PC0) || (state_q == S_PI0);
  assign push_hi_w = (state_q == S_PF1) || (state_q == S_PC1) || (state_q == S_PI1);
  assign pop_lo_w  = (state_q == S_OI0) || (state_q == S_OC0) || (state_q == S_OF0);
  assign pop_hi_w  = (state_q == S_OI1) || (state_q == S_OC1) || (state_q == S_OF1);
  assign vec_rd_w  = (state_q == S_V0) || (state_q == S_V1) ||
                     (state_q == S_V2) || (state_q == S_V3);
  assign entry_done_w = (state_q == S_DONE) && !ret_q;

  // word being pushed in the current push state
  logic [WORD_W-1:0] push_word;
  always_comb begin
    case (state_q)
      S_PF0, S_PF1: push_word = fl_q;
      S_PC0, S_PC1: push_word = cs_q;
      default:      push_word = ip_q;
    endcase
  end

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (push_lo_w) begin
      mem_addr_o  = phys(ss_q, sp_q - 16'd2);
      mem_wdata_o = push_word[7:0];
    end else if (push_hi_w) begin
      mem_addr_o  = phys(ss_q, sp_q + 16'd1);
      mem_wdata_o = push_word[15:8];
    end else if (pop_lo_w) begin
      mem_addr_o  = phys(ss_q, sp_q);
    end else if (pop_hi_w) begin
      mem_addr_o  = phys(ss_q, sp_q + 16'd1);
    end else if (vec_rd_w) begin
      mem_addr_o  = vec_addr(vtype_q, 2'(state_q - S_V0));
    end
  end

  assign mem_wr_o = push_lo_w || push_hi_w;
  assign mem_rd_o = pop_lo_w || pop_hi_w || vec_rd_w;
  assign inta_o   = (state_q == S_INTA);
  assign busy_o   = !idle_w;
  assign done_o   = (state_q == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      vtype_q <= '0;
      lo_q    <= '0;
      ret_q   <= 1'b0;
      cs_q    <= '0;
      ip_q    <= '0;
      ss_q    <= '0;
      sp_q    <= '0;
      fl_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (reg_ld_i) begin
            cs_q <= cs_ld_i;
            ip_q <= ip_ld_i;
            ss_q <= ss_ld_i;
            sp_q <= sp_ld_i;
            fl_q <= flags_ld_i;
          end else if (boundary_i && arb_take) begin
            vtype_q <= arb_type;
            ret_q   <= 1'b0;
            state_q <= arb_intr ? S_INTA : S_PF0;
          end else if (boundary_i && arb_ret) begin
            ret_q   <= 1'b1;
            state_q <= S_OI0;
          end
        end
        S_INTA: begin
          vtype_q <= mem_rdata_i;
          state_q <= S_PF0;
        end
        S_PF0: begin sp_q <= sp_q - 16'd2; state_q <= S_PF1; end
        S_PF1: begin
          fl_q[TF_BIT] <= 1'b0;
          fl_q[IF_BIT] <= 1'b0;
          state_q <= S_PC0;
        end
        S_PC0: begin sp_q <= sp_q - 16'd2; state_q <= S_PC1; end
        S_PC1: state_q <= S_PI0;
        S_PI0: begin sp_q <= sp_q - 16'd2; state_q <= S_PI1; end
        S_PI1: state_q <= S_V0;
        S_V0:  begin lo_q <= mem_rdata_i; state_q <= S_V1; end
        S_V1:  begin ip_q <= {mem_rdata_i, lo_q}; state_q <= S_V2; end
        S_V2:  begin lo_q <= mem_rdata_i; state_q <= S_V3; end
        S_V3:  begin cs_q <= {mem_rdata_i, lo_q}; state_q <= S_DONE; end
        S_OI0: begin lo_q <= mem_rdata_i; state_q <= S_OI1; end
        S_OI1: begin
          ip_q <= {mem_rdata_i, lo_q}; sp_q <= sp_q + 16'd2; state_q <= S_OC0;
        end
        S_OC0: begin lo_q <= mem_rdata_i; state_q <= S_OC1; end
        S_OC1: begin
          cs_q <= {mem_rdata_i, lo_q}; sp_q <= sp_q + 16'd2; state_q <= S_OF0;
        end
        S_OF0: begin lo_q <= mem_rdata_i; state_q <= S_OF1; end
        S_OF1: begin
          fl_q <= {mem_rdata_i, lo_q}; sp_q <= sp_q + 16'd2; state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cs_o    = cs_q;
  assign ip_o    = ip_q;
  assign ss_o    = ss_q;
  assign sp_o    = sp_q;
  assign flags_o = fl_q;
endmodule

// File: rtl/vis_int_seq_chk.sv
`timescale 1ns/1ps
module vis_int_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic        done_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        inta_o,
  input logic [19:0] mem_addr_o,
  input logic        vec_rd,
  input logic        entry_done,
  input logic        push_lo,
  input logic [15:0] sp_o,
  input logic [15:0] flags_o,
  input logic        nmi_i,
  input logic        nmi_pend
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R11
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_rd_o && !mem_wr_o && !inta_o));
  // R2
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |-> (mem_rd_o && mem_addr_o < 20'h00400));
  // R4
  entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> (!flags_o[8] && !flags_o[9]));
  // R3
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_lo |=> (sp_o == $past(sp_o) - 16'd2));
  // R6
  nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_i) |=> nmi_pend);
endmodule

bind vis_int_seq vis_int_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .inta_o(inta_o),
  .mem_addr_o(mem_addr_o), .vec_rd(vec_rd_w), .entry_done(entry_done_w),
  .push_lo(push_lo_w), .sp_o(sp_o), .flags_o(flags_o),
  .nmi_i(nmi_i), .nmi_pend(nmi_pend)
);

// File: tb/vis_int_seq_bench.sv
`timescale 1ns/1ps
module vis_int_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        boundary, div_err, brk, into, sw_int, iret, nmi, intr;
  logic [7:0]  sw_type, intr_vec;
  logic        inta, mem_rd, mem_wr, reg_ld, busy, done;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] cs_ld, ip_ld, ss_ld, sp_ld, fl_ld;
  logic [15:0] cs_o, ip_o, ss_o, sp_o, fl_o;

  logic [7:0] mem [0:4095];
  always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
  assign mem_rdata = inta ? intr_vec : mem[mem_addr[11:0]];

  vis_int_seq u_vis_int_seq (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .div_err_i(div_err),
    .brk_i(brk), .into_i(into), .sw_int_i(sw_int), .sw_type_i(sw_type),
    .iret_i(iret), .nmi_i(nmi), .intr_i(intr), .inta_o(inta),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .reg_ld_i(reg_ld),
    .cs_ld_i(cs_ld), .ip_ld_i(ip_ld), .ss_ld_i(ss_ld), .sp_ld_i(sp_ld),
    .flags_ld_i(fl_ld), .cs_o(cs_o), .ip_o(ip_o), .ss_o(ss_o), .sp_o(sp_o),
    .flags_o(fl_o), .busy_o(busy), .done_o(done)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  function automatic logic [15:0] exp_ip(input int t);
    return (t == 41) ? 16'h00AE : 16'h0100 + 16'(t);
  endfunction
  function automatic logic [15:0] exp_cs(input int t);
    return (t == 41) ? 16'h1234 : 16'h3000 + 16'(t);
  endfunction

  task automatic load(input logic [15:0] c, input logic [15:0] i, input logic [15:0] f);
    cs_ld = c; ip_ld = i; ss_ld = 16'h0080; sp_ld = 16'h0100; fl_ld = f;
    reg_ld = 1'b1;
    @(negedge clk);
    reg_ld = 1'b0;
  endtask

  task automatic pulse();
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0; div_err = 0; brk = 0; into = 0; sw_int = 0; iret = 0;
  endtask

  task automatic wait_done(output int nb, output int ni);
    nb = 0; ni = 0;
    for (int k = 0; k < 40; k++) begin
      if (busy) nb++;
      if (inta) ni++;
      if (done) return;
      @(negedge clk);
    end
    chk(0, "R11", "done never seen", 0, 1);
  endtask

  task automatic t_reset();
    chk_eq("R1", "busy", busy, 0);
    chk_eq("R1", "done", done, 0);
    chk_eq("R1", "cs|ip|sp|flags", cs_o | ip_o | sp_o | fl_o, 0);
    chk_eq("R1", "bus strobes", {mem_rd, mem_wr, inta}, 0);
  endtask

  task automatic t_swint_iret();
    int nb, ni;
    load(16'h5000, 16'h0040, 16'h0BD5);
    chk_eq("R12", "loaded cs", cs_o, 16'h5000);
    chk_eq("R12", "loaded sp", sp_o, 16'h0100);
    sw_int = 1; sw_type = 8'd41;
    pulse();
    wait_done(nb, ni);
    chk_eq("R11", "entry busy cycles", nb, 11);
    chk_eq("R2", "type 41 ip", ip_o, 16'h00AE);
    chk_eq("R2", "type 41 cs", cs_o, 16'h1234);
    chk_eq("R3", "sp after entry", sp_o, 16'h00FA);
    chk_eq("R4", "flags after entry", fl_o, 16'h08D5);
    chk_eq("R3", "flags image", {mem[12'h8FF], mem[12'h8FE]}, 16'h0BD5);
    chk_eq("R3", "cs image", {mem[12'h8FD], mem[12'h8FC]}, 16'h5000);
    chk_eq("R3", "ip image", {mem[12'h8FB], mem[12'h8FA]}, 16'h0040);
    @(negedge clk);
    chk_eq("R11", "done one cycle", {done, busy}, 0);
    iret = 1;
    pulse();
    wait_done(nb, ni);
    chk_eq("R11", "return busy cycles", nb, 7);
    chk_eq("R5", "restored ip", ip_o, 16'h0040);
    chk_eq("R5", "restored cs", cs_o, 16'h5000);
    chk_eq("R5", "restored flags", fl_o, 16'h0BD5);
    chk_eq("R5", "restored sp", sp_o, 16'h0100);
    @(negedge clk);
    // trace flag now set again: an empty boundary single-steps
    pulse();
    wait_done(nb, ni);
    chk_eq("R9", "single-step ip", ip_o, exp_ip(1));
    chk_eq("R9", "single-step cs", cs_o, exp_cs(1));
    @(negedge clk);
  endtask

  task automatic t_intr();
    int nb, ni;
    load(16'h5000, 16'h0040, 16'h0000);
    intr = 1; intr_vec = 8'h20;
    pulse();
    @(negedge clk);
    chk_eq("R7", "masked intr leaves idle", busy, 0);
    chk_eq("R7", "masked intr ip", ip_o, 16'h0040);
    load(16'h5000, 16'h0040, 16'h0200);
    pulse();
    wait_done(nb, ni);
    chk_eq("R11", "acknowledged entry busy", nb, 12);
    chk_eq("R7", "acknowledge cycles", ni, 1);
    chk_eq("R7", "bus type ip", ip_o, exp_ip(32));
    intr = 0;
    @(negedge clk);
  endtask

  task automatic t_nmi();
    int nb, ni;
    load(16'h5000, 16'h0040, 16'h0000);
    nmi = 1;
    @(negedge clk);
    pulse();
    wait_done(nb, ni);
    chk_eq("R6", "nmi ip with IF clear", ip_o, exp_ip(2));
    @(negedge clk);
    load(16'h5000, 16'h0040, 16'h0000);
    pulse();
    @(negedge clk);
    chk_eq("R6", "held nmi no retrigger", busy, 0);
    nmi = 0;
    @(negedge clk);
  endtask

  task automatic t_prio();
    int nb, ni;
    load(16'h5000, 16'h0040, 16'h0000);
    nmi = 1;
    @(negedge clk);
    div_err = 1;
    pulse();
    wait_done(nb, ni);
    chk_eq("R10", "divide beats nmi", ip_o, exp_ip(0));
    @(negedge clk);
    load(16'h5000, 16'h0040, 16'h0000);
    pulse();
    wait_done(nb, ni);
    chk_eq("R10", "pending nmi next", ip_o, exp_ip(2));
    nmi = 0;
    @(negedge clk);
    load(16'h5000, 16'h0040, 16'h0300);
    intr = 1; intr_vec = 8'h20;
    pulse();
    wait_done(nb, ni);
    chk_eq("R10", "intr beats single-step", ip_o, exp_ip(32));
    intr = 0;
    @(negedge clk);
  endtask

  task automatic t_internal();
    int nb, ni;
    load(16'h5000, 16'h0040, 16'h0000);
    into = 1;
    pulse();
    @(negedge clk);
    chk_eq("R8", "overflow trap with OF clear", busy, 0);
    load(16'h5000, 16'h0040, 16'h0800);
    into = 1;
    pulse();
    wait_done(nb, ni);
    chk_eq("R8", "overflow trap type", ip_o, exp_ip(4));
    @(negedge clk);
    load(16'h5000, 16'h0040, 16'h0000);
    brk = 1;
    pulse();
    wait_done(nb, ni);
    chk_eq("R8", "breakpoint type", ip_o, exp_ip(3));
    @(negedge clk);
  endtask

  task automatic t_busy_load();
    int nb, ni;
    load(16'h5000, 16'h0040, 16'h0000);
    sw_int = 1; sw_type = 8'd7;
    pulse();
    @(negedge clk);
    cs_ld = 16'hDEAD; ip_ld = 16'hBEEF; sp_ld = 16'h0777; fl_ld = 16'hFFFF;
    reg_ld = 1;
    @(negedge clk);
    reg_ld = 0;
    wait_done(nb, ni);
    chk_eq("R12", "busy load ip", ip_o, exp_ip(7));
    chk_eq("R12", "busy load cs", cs_o, exp_cs(7));
    chk_eq("R12", "busy load sp", sp_o, 16'h00FA);
    chk_eq("R12", "busy load flags", fl_o, 16'h0000);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1200000;
    chk(0, "R11", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    boundary = 0; div_err = 0; brk = 0; into = 0; sw_int = 0; iret = 0;
    nmi = 0; intr = 0; sw_type = 0; intr_vec = 0; reg_ld = 0;
    cs_ld = 0; ip_ld = 0; ss_ld = 0; sp_ld = 0; fl_ld = 0;
    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    for (int t = 0; t < 256; t++) begin
      mem[t*4]     = exp_ip(t)[7:0];
      mem[t*4 + 1] = exp_ip(t)[15:8];
      mem[t*4 + 2] = exp_cs(t)[7:0];
      mem[t*4 + 3] = exp_cs(t)[15:8];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_swint_iret();
    t_intr();
    t_nmi();
    t_prio();
    t_internal();
    t_busy_load();
    summary();
  end
endmodule